// File: doc/BRIEF.md
# Serial Register-Write Target with Word-Delayed Echo

This block sits on the target side of a four-wire serial link (SPI mode 0) and accepts register-write commands from a host. The first 32-bit word of each chip-select window is a command header. It names a 4-bit register bank, a 16-bit start address and a word count, and it carries an odd-parity bit. Each word that follows is written into the next register in turn. The writes go out on a one-cycle strobe bus: enable, bank, address and data.

While the host shifts a frame in, the target drives back on MISO every bit it has received, exactly 32 bit times later. The host can then compare the returned header and data with what it sent and so confirm that the transfer arrived intact. The block samples the serial pins with the system clock through short synchronizers and takes each MOSI bit on a rising serial clock edge. A header that fails its checks blocks every write of its frame and raises a sticky error flag.

Top module: `spi_regwrite_echo`

## Requirements
- R1: Header fields are decoded MSB-first: bit 31 = data flag, bit 29 = write, bits 27:24 = bank (driven on `regWrSel`), bits 23:8 = start address, bits 7:1 = word count minus one. Each data word is written unchanged on `regWrData`.
- R2: A header is accepted only when the XOR of all 32 of its bits is 1 (odd parity). A header with bad parity produces no register writes in its frame.
- R3: A header with bit 31 set, or with bit 29 clear, produces no register writes in its frame.
- R4: `hdrErr` goes to 1 when a header is rejected under R2 or R3. It stays at 1 through later good frames until reset.
- R5: Successive writes in one frame use consecutive addresses starting at the header address. The address wraps from 0xFFFF to 0x0000.
- R6: An accepted frame writes exactly min(count, words sent after the header) registers. Count can reach 128. Words beyond the count are ignored.
- R7: A write is issued only after all 32 bits of its word have arrived. `regWrEn` is high for a single clock per write, and a partial word never causes a write.
- R8: MISO bit n of a frame equals MOSI bit n−32 of the same frame. The first 32 MISO bits of every frame are 0.
- R9: Raising chip select at any point ends the frame and clears the bit position, header state and echo history. The next frame decodes its header from its own first bit.
- R10: After reset, `regWrEn`, `hdrErr` and `spiMiso` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiSclk | input | 1 | Serial clock from host, idle low |
| spiCsN | input | 1 | Active-low chip select |
| spiMosi | input | 1 | Serial data from host |
| spiMiso | output | 1 | Serial echo to host |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrSel | output | 4 | Register bank of the write |
| regWrAddr | output | 16 | Register address of the write |
| regWrData | output | 32 | Register write data |
| hdrErr | output | 1 | Sticky rejected-header flag |

## Verification
On the last rising serial edge of a data word, the same shift register both completes the word that feeds a register write and advances the MISO echo by one bit. The bench therefore records MISO on every bit of every frame. It compares the echoed words against the words sent one position earlier, and it logs every write strobe to check address, bank and data. Frames with surplus words, rejected headers, a 128-word burst, an address wrap and a frame cut off mid-word test whether each write decision stays independent of the echo stream.

// File: rtl/spi_echo_pkg.sv
package spi_echo_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 16;
  localparam int SEL_W  = 4;
  localparam int LEN_W  = 7;

  // header bit positions (decoded by the host side as well)
  localparam int HDR_DATA_BIT = 31;
  localparam int HDR_WR_BIT   = 29;
  localparam int HDR_SEL_LSB  = 24;
  localparam int HDR_ADDR_LSB = 8;
  localparam int HDR_LEN_LSB  = 1;

  typedef struct packed {
    logic clear;    // chip select idle: wipe shift state
    logic shiftIn;  // rising serial edge: take one MOSI bit
    logic loadHdr;  // accepted header: latch bank and address
    logic issueWr;  // complete data word: emit a register write
  } dpStrobes_t;
endpackage

// File: rtl/spi_echo_ctrl.sv
module spi_echo_ctrl
  import spi_echo_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclkRaw,
  input  logic               csNRaw,
  input  logic               mosiRaw,
  input  logic [WORD_W-1:0]  rxWord,
  output dpStrobes_t         strb,
  output logic               mosiBit,
  output logic               frameOk,
  output logic               hdrErr
);
  localparam int BIT_CNT_W = $clog2(WORD_W);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(WORD_W - 1);

  logic [SYNC_STAGES-1:0] sclkSync, csSync, mosiSync;
  logic                   sclkPrev;
  logic                   csActive, sclkRise;
  logic [BIT_CNT_W-1:0]   bitCnt;
  logic                   wordDone, hdrSeen, hdrGood;
  logic [LEN_W:0]         wordsLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkRaw};
      csSync   <= {csSync[SYNC_STAGES-2:0], csNRaw};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiRaw};
      sclkPrev <= sclkSync[SYNC_STAGES-1];
    end
  end

  assign csActive = ~csSync[SYNC_STAGES-1];
  assign sclkRise = csActive & sclkSync[SYNC_STAGES-1] & ~sclkPrev;
  assign mosiBit  = mosiSync[SYNC_STAGES-1];

  // odd parity over the full header, control frame, write operation
  assign hdrGood = (^rxWord) & ~rxWord[HDR_DATA_BIT] & rxWord[HDR_WR_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      wordDone  <= 1'b0;
      hdrSeen   <= 1'b0;
      frameOk   <= 1'b0;
      wordsLeft <= '0;
    end else if (!csActive) begin
      bitCnt    <= '0;
      wordDone  <= 1'b0;
      hdrSeen   <= 1'b0;
      frameOk   <= 1'b0;
      wordsLeft <= '0;
    end else begin
      wordDone <= sclkRise && (bitCnt == LAST_BIT);
      if (sclkRise) bitCnt <= bitCnt + 1'b1;
      if (wordDone) begin
        if (!hdrSeen) begin
          hdrSeen <= 1'b1;
          if (hdrGood) begin
            frameOk   <= 1'b1;
            wordsLeft <= {1'b0, rxWord[HDR_LEN_LSB +: LEN_W]} + 1'b1;
          end
        end else if (frameOk && wordsLeft != '0) begin
          wordsLeft <= wordsLeft - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hdrErr <= 1'b0;
    else if (csActive && wordDone && !hdrSeen && !hdrGood) hdrErr <= 1'b1;
  end

  always_comb begin
    strb.clear   = ~csActive;
    strb.shiftIn = sclkRise;
    strb.loadHdr = wordDone & ~hdrSeen & hdrGood & csActive;
    strb.issueWr = wordDone & hdrSeen & frameOk & csActive & (wordsLeft != '0);
  end

  // R4: the error flag never falls without reset
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    hdrErr |=> hdrErr);

  // R9: an idle chip select leaves the frame state cleared
  a_r9_cs_clears: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> (bitCnt == '0 && !hdrSeen && !frameOk));
endmodule

// File: rtl/spi_echo_dp.sv
module spi_echo_dp
  import spi_echo_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strb,
  input  logic               mosiBit,
  output logic [WORD_W-1:0]  rxWord,
  output logic               spiMiso,
  output logic               regWrEn,
  output logic [SEL_W-1:0]   regWrSel,
  output logic [ADDR_W-1:0]  regWrAddr,
  output logic [WORD_W-1:0]  regWrData
);
  logic [WORD_W-1:0] rxShift;
  logic [ADDR_W-1:0] addrReg;
  logic [SEL_W-1:0]  selReg;

  // one register serves as word assembler and as 32-bit echo delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxShift <= '0;
    else if (strb.clear)   rxShift <= '0;
    else if (strb.shiftIn) rxShift <= {rxShift[WORD_W-2:0], mosiBit};
  end

  assign rxWord  = rxShift;
  assign spiMiso = rxShift[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      selReg    <= '0;
      regWrEn   <= 1'b0;
      regWrSel  <= '0;
      regWrAddr <= '0;
      regWrData <= '0;
    end else begin
      regWrEn <= 1'b0;
      if (strb.loadHdr) begin
        addrReg <= rxShift[HDR_ADDR_LSB +: ADDR_W];
        selReg  <= rxShift[HDR_SEL_LSB +: SEL_W];
      end else if (strb.issueWr) begin
        regWrEn   <= 1'b1;
        regWrSel  <= selReg;
        regWrAddr <= addrReg;
        regWrData <= rxShift;
        addrReg   <= addrReg + 1'b1;
      end
    end
  end

  // R7: writes are single-cycle pulses
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R8: an idle frame returns zero on MISO
  a_r8_miso_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !spiMiso);
endmodule

// File: rtl/spi_regwrite_echo.sv
module spi_regwrite_echo
  import spi_echo_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic              regWrEn,
  output logic [SEL_W-1:0]  regWrSel,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [WORD_W-1:0] regWrData,
  output logic              hdrErr
);
  dpStrobes_t        strb;
  logic              mosiBit;
  logic              frameOk;
  logic [WORD_W-1:0] rxWord;

  spi_echo_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclkRaw (spiSclk),
    .csNRaw  (spiCsN),
    .mosiRaw (spiMosi),
    .rxWord  (rxWord),
    .strb    (strb),
    .mosiBit (mosiBit),
    .frameOk (frameOk),
    .hdrErr  (hdrErr)
  );

  spi_echo_dp i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .mosiBit   (mosiBit),
    .rxWord    (rxWord),
    .spiMiso   (spiMiso),
    .regWrEn   (regWrEn),
    .regWrSel  (regWrSel),
    .regWrAddr (regWrAddr),
    .regWrData (regWrData)
  );

  // R2/R3: a write only follows an accepted header
  a_r2_write_needs_good_hdr: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $past(frameOk));
endmodule

// File: tb/test_spi_regwrite_echo.sv
`timescale 1ns/1ps
module test_spi_regwrite_echo;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        spiSclk = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0;
  logic        spiMiso, regWrEn, hdrErr;
  logic [3:0]  regWrSel;
  logic [15:0] regWrAddr;
  logic [31:0] regWrData;

  spi_regwrite_echo i_spi_regwrite_echo (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .regWrEn(regWrEn),
    .regWrSel(regWrSel), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .hdrErr(hdrErr));

  always #2.5 clk = ~clk;

  int nChecks = 0, nFails = 0, wrCnt = 0;
  logic [15:0] wrAddrLog [0:255];
  logic [3:0]  wrSelLog  [0:255];
  logic [31:0] wrDataLog [0:255];
  logic [31:0] txWords   [0:159];
  logic [31:0] echoWords [0:159];
  bit          expErr = 1'b0;

  always @(negedge clk) begin
    if (regWrEn && wrCnt < 256) begin
      wrAddrLog[wrCnt] = regWrAddr;
      wrSelLog[wrCnt]  = regWrSel;
      wrDataLog[wrCnt] = regWrData;
    end
    if (regWrEn) wrCnt = wrCnt + 1;
  end

  typedef struct packed {
    logic [3:0]  sel;
    logic [15:0] addr;
    logic [6:0]  lenM1;
    logic        badPar;
    logic        dFlag;
    logic        rdOp;
    logic [7:0]  sent;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{4'h1, 16'h0010, 7'd0, 1'b0, 1'b0, 1'b0, 8'd1},
    '{4'hA, 16'h1234, 7'd3, 1'b0, 1'b0, 1'b0, 8'd4},
    '{4'h3, 16'h0200, 7'd1, 1'b0, 1'b0, 1'b0, 8'd4},
    '{4'h2, 16'h0300, 7'd2, 1'b1, 1'b0, 1'b0, 8'd3},
    '{4'h2, 16'h0400, 7'd0, 1'b0, 1'b1, 1'b0, 8'd1},
    '{4'h5, 16'h0500, 7'd0, 1'b0, 1'b0, 1'b1, 8'd1},
    '{4'h7, 16'hFFFE, 7'd3, 1'b0, 1'b0, 1'b0, 8'd4}
  };

  function automatic logic [31:0] mkHdr(logic [3:0] sel, logic [15:0] addr,
      logic [6:0] lenM1, logic badPar, logic dFlag, logic rdOp);
    logic [31:0] h;
    h = {dFlag, 1'b0, ~rdOp, 1'b0, sel, addr, lenM1, 1'b0};
    h[0] = ~(^h[31:1]) ^ badPar;
    return h;
  endfunction

  function automatic logic [31:0] dataWord(int v, int i);
    return 32'h9E3779B9 * (v * 256 + i + 1);
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // send nWords words; if partBits >= 0 the last word is cut to partBits bits
  task automatic sendFrame(input int nWords, input int partBits);
    int total;
    total = (partBits < 0) ? nWords * 32 : (nWords - 1) * 32 + partBits;
    spiCsN = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < total; k++) begin
      spiMosi = txWords[k / 32][31 - (k % 32)];
      repeat (4) @(negedge clk);
      echoWords[k / 32][31 - (k % 32)] = spiMiso;
      spiSclk = 1'b1;
      repeat (4) @(negedge clk);
      spiSclk = 1'b0;
    end
    repeat (12) @(negedge clk);
    spiCsN  = 1'b1;
    spiMosi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic checkEcho(input int nWords, input string tag);
    bit ok;
    ok = (echoWords[0] == 32'h0);
    for (int w = 1; w < nWords; w++)
      if (echoWords[w] !== txWords[w - 1]) ok = 1'b0;
    check(ok, tag, echoWords[1], txWords[0]);
  endtask

  task automatic checkWrites(input int base, input int nExp, input logic [3:0] sel,
                             input logic [15:0] addr, input int firstWord, input string tag);
    check(wrCnt - base == nExp, {tag, " R6 write count"}, 32'(wrCnt - base), 32'(nExp));
    for (int i = 0; i < nExp && base + i < wrCnt; i++) begin
      check(wrAddrLog[base + i] == addr + 16'(i), {tag, " R5 address"},
            32'(wrAddrLog[base + i]), 32'(addr + 16'(i)));
      check(wrSelLog[base + i] == sel, {tag, " R1 bank"},
            32'(wrSelLog[base + i]), 32'(sel));
      check(wrDataLog[base + i] == txWords[firstWord + i], {tag, " R1 data"},
            wrDataLog[base + i], txWords[firstWord + i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int base, nExp, nWords;
    bit bad;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!regWrEn && !hdrErr && !spiMiso, "R10 reset outputs",
          {29'h0, regWrEn, hdrErr, spiMiso}, 32'h0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!regWrEn && !hdrErr && !spiMiso, "R10 after release",
          {29'h0, regWrEn, hdrErr, spiMiso}, 32'h0);

    // table of frames: header, data words, one trailing word
    for (int v = 0; v < NVEC; v++) begin
      vec_t t;
      t = VECS[v];
      txWords[0] = mkHdr(t.sel, t.addr, t.lenM1, t.badPar, t.dFlag, t.rdOp);
      nWords = int'(t.sent) + 2;
      for (int i = 1; i < nWords; i++) txWords[i] = dataWord(v, i);
      bad  = t.badPar | t.dFlag | t.rdOp;
      nExp = bad ? 0 : ((int'(t.lenM1) + 1 < int'(t.sent)) ? int'(t.lenM1) + 1 : int'(t.sent));
      base = wrCnt;
      sendFrame(nWords, -1);
      // R2/R3 rejected headers give zero writes; accepted ones per R1/R5/R6
      checkWrites(base, nExp, t.sel, t.addr, 1, bad ? "R2 R3 reject" : "R1 frame");
      checkEcho(nWords, "R8 echo");
      expErr = expErr | bad;
      check(hdrErr == expErr, "R4 sticky flag", {31'h0, hdrErr}, {31'h0, expErr});
    end

    // R6: longest burst of 128 words
    txWords[0] = mkHdr(4'h6, 16'h1000, 7'd127, 1'b0, 1'b0, 1'b0);
    for (int i = 1; i < 130; i++) txWords[i] = dataWord(40, i);
    base = wrCnt;
    sendFrame(130, -1);
    checkWrites(base, 128, 4'h6, 16'h1000, 1, "R6 max burst");
    checkEcho(130, "R8 long echo");

    // R7/R9: frame cut mid-word, then a fresh frame
    txWords[0] = mkHdr(4'h1, 16'h0700, 7'd2, 1'b0, 1'b0, 1'b0);
    txWords[1] = 32'hCAFE0001;
    txWords[2] = 32'hFFFFFFFF;
    base = wrCnt;
    sendFrame(3, 10);
    checkWrites(base, 1, 4'h1, 16'h0700, 1, "R7 partial word");
    txWords[0] = mkHdr(4'h4, 16'h0800, 7'd0, 1'b0, 1'b0, 1'b0);
    txWords[1] = 32'h0BADF00D;
    txWords[2] = 32'h12345678;
    base = wrCnt;
    sendFrame(3, -1);
    checkWrites(base, 1, 4'h4, 16'h0800, 1, "R9 after abort");
    checkEcho(3, "R9 echo restart");
    check(!spiMiso && !regWrEn, "R9 idle outputs", {30'h0, spiMiso, regWrEn}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule